// File: doc/BRIEF.md
# Misaligned Word Access Sequencer

This block sits between a processor core and a 16-bit memory bus with a 20-bit byte address. The core hands it one request at a time: a byte or a word, a read or a write, or an instruction fetch. The block turns each request into one or two bus cycles and returns a single completion to the core.

A word is two neighbouring bytes and is named by the lower of the two addresses. Byte order is big-endian, so the byte at the lower address is the most significant byte of the word. A word at an even address goes out as one full-width cycle. A data word at an odd address is split into two byte cycles, at A and then at A+1. The two bytes are assembled into one result on a read, or sent out one byte at a time on a write. A+1 is formed over all 20 bits, so stepping past the end of a 64K bank carries into the upper four bits. While the request is in progress the core sees a busy signal, and the completion flags whether the request was split.

An instruction fetch must be word aligned. A fetch at an odd address is never split. It raises an alignment error and issues no bus cycle.

Top module: `misaligned_seq`

## Requirements
- R1: During and right after reset (`rst_n` low), `req_busy`, `bus_cyc`, `rsp_valid` and `align_err` are all 0.
- R2: A byte read at any address A issues exactly one read cycle at address A. The strobe `bus_be` is 2'b10 (upper lane, bits 15:8) when A is even and 2'b01 (lower lane, bits 7:0) when A is odd. The byte from that lane is returned zero-extended in `rsp_rdata[7:0]`.
- R3: A byte write at address A issues exactly one write cycle at A, with the strobe chosen as in R2. `req_wdata[7:0]` appears on the selected lane and the other lane is 0.
- R4: A word read or write at an even address A issues one cycle at A with `bus_be` = 2'b11. On a write, `bus_wdata` equals `req_wdata`. On a read, `rsp_rdata` equals `bus_rdata`: bits 15:8 hold the byte at A and bits 7:0 the byte at A+1.
- R5: A data word read at an odd address A issues two read cycles: at A with `bus_be` = 2'b01, then at A+1 with `bus_be` = 2'b10. The result is {byte from the first cycle's lower lane, byte from the second cycle's upper lane}.
- R6: A data word write at an odd address A issues two write cycles. The first is at A, with `bus_be` = 2'b01 and `bus_wdata` = {8'h00, req_wdata[15:8]}. The second is at A+1, with `bus_be` = 2'b10 and `bus_wdata` = {req_wdata[7:0], 8'h00}.
- R7: The second address of a split is A+1 computed over all 20 bits. For example, 20'h0FFFF is followed by 20'h10000, and 20'hFFFFF is followed by 20'h00000.
- R8: A request is taken when `req_valid` is high and `req_busy` is low. `req_busy` is high from the cycle after acceptance until the last `bus_ack` is taken. Requests presented while busy are ignored and cause no bus cycle.
- R9: A fetch (`req_fetch` = 1) is a word read whatever the value of `req_word`. At an even address it behaves as in R4. At an odd address, `align_err` is high for exactly one cycle after acceptance, and no bus cycle and no `rsp_valid` follow.
- R10: `rsp_valid` is high for exactly one cycle, in the cycle after the last `bus_ack`. In that same cycle `rsp_split` is 1 only if the request took two bus cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_fetch | input | 1 | Instruction fetch (word read, must be even) |
| req_addr | input | 20 | Byte address of the request |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| req_busy | output | 1 | Request in progress; new requests ignored |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read result |
| rsp_split | output | 1 | Completed request used two bus cycles |
| align_err | output | 1 | Odd-address fetch rejected |
| bus_cyc | output | 1 | Bus cycle active |
| bus_we | output | 1 | Bus cycle is a write |
| bus_addr | output | 20 | Bus byte address |
| bus_be | output | 2 | Lane strobes: bit 1 = bits 15:8, bit 0 = bits 7:0 |
| bus_wdata | output | 16 | Bus write data |
| bus_ack | input | 1 | Bus cycle complete |
| bus_rdata | input | 16 | Bus read data, valid with bus_ack |

## Verification
A wrong sequencer state shows up at the bus at once. It appears as a missing or extra cycle, a second address that is not A+1 (most visibly at a bank edge), or a strobe on the wrong lane, and the bus log catches it when the request completes. A wrong latched byte or lane choice shows up only in `rsp_rdata` at the completion pulse. A stuck busy or a request taken while busy shows up within one cycle of completion, as a late pulse or a stray bus cycle.

// File: rtl/misaligned_seq.sv
module misaligned_seq #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_word,
  input  logic          req_fetch,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  output logic          req_busy,
  output logic          rsp_valid,
  output logic [15:0]   rsp_rdata,
  output logic          rsp_split,
  output logic          align_err,
  output logic          bus_cyc,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_be,
  output logic [15:0]   bus_wdata,
  input  logic          bus_ack,
  input  logic [15:0]   bus_rdata
);
  typedef enum logic [1:0] {S_IDLE, S_FIRST, S_SECOND} state_t;
  state_t state;

  logic [AW-1:0] r_addr;
  logic [15:0]   r_wdata;
  logic          r_we, r_word;
  logic [7:0]    r_hi;

  wire split  = r_word & r_addr[0];
  wire take   = req_valid & (state == S_IDLE);
  wire want_w = req_fetch | req_word;
  wire bad    = req_fetch & req_addr[0];
  wire last   = bus_ack & ((state == S_SECOND) | ((state == S_FIRST) & ~split));

  assign req_busy = (state != S_IDLE);
  assign bus_cyc  = (state != S_IDLE);
  assign bus_we   = r_we;
  assign bus_addr = (state == S_SECOND) ? r_addr + AW'(1) : r_addr;

  wire       byte_cyc = ~r_word | split;
  wire [7:0] wbyte    = (split & (state == S_FIRST)) ? r_wdata[15:8] : r_wdata[7:0];
  wire [7:0] rbyte    = bus_addr[0] ? bus_rdata[7:0] : bus_rdata[15:8];

  assign bus_be    = !byte_cyc ? 2'b11 : (bus_addr[0] ? 2'b01 : 2'b10);
  assign bus_wdata = !byte_cyc ? r_wdata :
                     (bus_addr[0] ? {8'h00, wbyte} : {wbyte, 8'h00});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      r_addr    <= '0;
      r_wdata   <= '0;
      r_we      <= 1'b0;
      r_word    <= 1'b0;
      r_hi      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_split <= 1'b0;
      align_err <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      align_err <= 1'b0;
      case (state)
        S_IDLE: if (take) begin
          if (bad) begin
            align_err <= 1'b1;
          end else begin
            r_addr  <= req_addr;
            r_wdata <= req_wdata;
            r_we    <= req_write & ~req_fetch;
            r_word  <= want_w;
            state   <= S_FIRST;
          end
        end
        S_FIRST: if (bus_ack) begin
          if (split) begin
            r_hi  <= rbyte;
            state <= S_SECOND;
          end else begin
            state <= S_IDLE;
          end
        end
        S_SECOND: if (bus_ack) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
      if (last) begin
        rsp_valid <= 1'b1;
        rsp_split <= split;
        if (!r_we)
          rsp_rdata <= !r_word ? {8'h00, rbyte} : (split ? {r_hi, rbyte} : bus_rdata);
      end
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !bus_cyc && !rsp_valid && !align_err);
  // R2
  lane_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc |-> (bus_be == 2'b11 && !bus_addr[0]) || $onehot(bus_be));
  // R7
  carry_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FIRST && bus_ack && split) |=> bus_addr == $past(bus_addr) + AW'(1));
  // R9
  fetch_nobus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> !bus_cyc && !rsp_valid);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && !bus_ack) |=> bus_cyc && $stable(bus_addr));
endmodule

// File: tb/tb_misaligned_seq.sv
module tb_misaligned_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0, req_fetch = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_busy, rsp_valid, rsp_split, align_err, bus_cyc, bus_we;
  logic [15:0] rsp_rdata, bus_wdata;
  logic [19:0] bus_addr;
  logic [1:0]  bus_be;
  logic bus_ack = 1'b0;
  logic [15:0] bus_rdata = '0;

  always #2.5 clk = ~clk;

  misaligned_seq dut (.*);

  int errors = 0, checks = 0;
  int log_n = 0;
  logic [19:0] log_a [0:1023];
  logic [1:0]  log_be[0:1023];
  logic        log_we[0:1023];
  logic [15:0] log_wd[0:1023];

  function automatic logic [7:0] mem(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h5A;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  initial begin : slave
    int wc;
    wc = 0;
    forever begin
      @(negedge clk);
      if (bus_ack) begin
        bus_ack = 1'b0;
        wc = $urandom % 3;
      end else if (bus_cyc) begin
        if (wc == 0) begin
          bus_rdata = {mem({bus_addr[19:1], 1'b0}), mem({bus_addr[19:1], 1'b1})};
          log_a[log_n % 1024]  = bus_addr;
          log_be[log_n % 1024] = bus_be;
          log_we[log_n % 1024] = bus_we;
          log_wd[log_n % 1024] = bus_wdata;
          log_n++;
          bus_ack = 1'b1;
        end else wc--;
      end
    end
  end

  task automatic run(input logic f, input logic w, input logic wd, input logic [19:0] a,
                     input logic [15:0] d, input string tag_in);
    string tag;
    int base, n, k;
    logic isw, sp;
    logic [19:0] ea[2];
    logic [1:0]  eb[2];
    logic [15:0] ed[2];
    logic [15:0] er;
    isw = f | wd;
    sp  = isw & a[0];
    tag = tag_in;
    if (tag == "") begin
      if (f) tag = "R9";
      else if (!isw) tag = w ? "R3" : "R2";
      else if (!sp) tag = "R4";
      else tag = w ? "R6" : "R5";
    end
    if (!isw) begin
      n = 1; ea[0] = a; eb[0] = a[0] ? 2'b01 : 2'b10;
      ed[0] = a[0] ? {8'h00, d[7:0]} : {d[7:0], 8'h00};
      er = {8'h00, mem(a)};
    end else if (!sp) begin
      n = 1; ea[0] = a; eb[0] = 2'b11; ed[0] = d;
      er = {mem(a), mem(a + 20'd1)};
    end else begin
      n = 2; ea[0] = a; ea[1] = a + 20'd1; eb[0] = 2'b01; eb[1] = 2'b10;
      ed[0] = {8'h00, d[15:8]}; ed[1] = {d[7:0], 8'h00};
      er = {mem(a), mem(a + 20'd1)};
    end
    base = log_n;
    @(negedge clk);
    req_valid = 1'b1; req_fetch = f; req_write = w; req_word = wd; req_addr = a; req_wdata = d;
    @(negedge clk);
    if (f && a[0]) begin
      req_valid = 1'b0;
      chk(align_err === 1'b1, "R9 align_err", align_err, 1);
      chk(req_busy === 1'b0, "R9 busy", req_busy, 0);
      @(negedge clk);
      chk(align_err === 1'b0, "R9 err pulse", align_err, 0);
      chk(log_n == base && !bus_cyc && !rsp_valid, "R9 no bus", log_n - base, 0);
      return;
    end
    chk(req_busy === 1'b1, "R8 busy", req_busy, 1);
    req_addr = ~a; req_write = ~w; req_wdata = ~d;
    @(negedge clk);
    req_valid = 1'b0;
    k = 0;
    while (!rsp_valid && k < 20) begin @(negedge clk); k++; end
    chk(rsp_valid === 1'b1, {tag, " R10 done"}, rsp_valid, 1);
    chk(rsp_split === sp, {tag, " R10 split"}, rsp_split, sp);
    if (!w || f) chk(rsp_rdata === er, {tag, " rdata"}, rsp_rdata, er);
    chk(log_n - base == n, {tag, " cycles"}, log_n - base, n);
    for (int i = 0; i < n && i < log_n - base; i++) begin
      int j;
      j = (base + i) % 1024;
      chk(log_a[j] === ea[i], {tag, " addr"}, log_a[j], ea[i]);
      chk(log_be[j] === eb[i], {tag, " be"}, log_be[j], eb[i]);
      chk(log_we[j] === (w & ~f), {tag, " we"}, log_we[j], w & ~f);
      if (w && !f) chk(log_wd[j] === ed[i], {tag, " wdata"}, log_wd[j], ed[i]);
    end
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R10 pulse", rsp_valid, 0);
    chk(!bus_cyc && log_n - base == n, "R8 ignored while busy", log_n - base, n);
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h1234_5678));
    repeat (2) @(negedge clk);
    chk(!req_busy && !bus_cyc && !rsp_valid && !align_err, "R1 in reset",
        {req_busy, bus_cyc, rsp_valid, align_err}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(!req_busy && !bus_cyc && !rsp_valid && !align_err, "R1 after reset",
        {req_busy, bus_cyc, rsp_valid, align_err}, 0);
    run(0, 0, 0, 20'h12344, 16'h0000, "R2");
    run(0, 0, 0, 20'h12345, 16'h0000, "R2");
    run(0, 1, 0, 20'h0A0A0, 16'hBEEF, "R3");
    run(0, 1, 0, 20'h0A0A1, 16'hBEEF, "R3");
    run(0, 0, 1, 20'h54320, 16'h0000, "R4");
    run(0, 1, 1, 20'h54322, 16'hCAFE, "R4");
    run(0, 0, 1, 20'h33331, 16'h0000, "R5");
    run(0, 1, 1, 20'h44447, 16'h1357, "R6");
    run(0, 0, 1, 20'h0FFFF, 16'h0000, "R7");
    run(0, 1, 1, 20'hFFFFF, 16'hA5C3, "R7");
    run(0, 0, 1, 20'h7FFFF, 16'h0000, "R7");
    run(1, 0, 0, 20'h00100, 16'h0000, "R9");
    run(1, 1, 1, 20'h00103, 16'h0000, "R9");
    run(1, 0, 0, 20'hFFFFF, 16'h0000, "R9");
    for (int i = 0; i < 300; i++) begin
      logic [19:0] a;
      a = $urandom;
      if ($urandom % 4 == 0) a[15:1] = '1;
      run(($urandom % 6) == 0, $urandom % 2, $urandom % 2, a, $urandom, "");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule